// File: doc/BRIEF.md
# Registered-Output Synchronous Queue

This block is a single-clock first-in first-out queue whose read data comes directly from a flop. Storage is split in two parts. A dual-port memory holds up to DEPTH-1 words and reads synchronously, so it can map onto block RAM. Its read register acts as the output stage and holds one more word. The output stage reloads itself from the memory whenever it is empty, or whenever it is being read while the memory still holds words. Together the two parts store exactly DEPTH words.

The producer writes `din` by raising `we` in a cycle where `writable` is high. The consumer takes `dout` by raising `re` in a cycle where `readable` is high. `level` counts every stored word, including the one in the output stage. Because the output stage always reloads through the memory's registered read port, a word written into an empty queue reaches `dout` two cycles after its write cycle. DEPTH may be any integer of 2 or more, and need not be a power of two.

Top module: `bfifo_out`

## Requirements
- R1: In the first cycle after `rst` is released, `level` is 0, `readable` is 0 and `writable` is 1.
- R2: From one cycle to the next, `level` rises by 1 for an accepted write (`we` and `writable`) and falls by 1 for an accepted read (`re` and `readable`). Both can happen in the same cycle.
- R3: `readable` is 0 whenever `level` is 0, and it is 1 whenever `level` is 2 or more.
- R4: `writable` is 1 exactly when `level` is below DEPTH. A write attempted while `writable` is 0 stores nothing and leaves `level` at DEPTH.
- R5: A word written while the queue is empty raises `readable` two cycles after its write cycle, not earlier. At that point `dout` equals the written word.
- R6: With `level` 1 and the word in the output stage, an accepted read drops `readable` in the next cycle. If no read occurs, `readable` stays 1.
- R7: Words leave in write order. While words remain queued behind the output stage, reads on consecutive cycles find `readable` high on every cycle.
- R8: If `re` was low in the previous cycle, `dout` keeps its value. The one exception is the cycle in which `readable` has just risen.
- R9: The queue accepts exactly DEPTH writes from empty before `writable` falls.
- R10: A read attempted while `readable` is 0 changes neither `level` nor `readable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | WIDTH | Write data |
| we | input | 1 | Write request |
| writable | output | 1 | Room for one more word |
| dout | output | WIDTH | Head word, driven from a flop |
| re | input | 1 | Read request |
| readable | output | 1 | `dout` holds a valid word |
| level | output | $clog2(DEPTH+1) | Stored word count, output stage included |

## Verification
Write and read acceptance take effect on `level` one cycle after the request cycle. A first word written into an empty queue appears on `dout` two cycles after it is written. After a read, `dout` shows the next word one cycle later. The bench changes inputs 1 ns after a rising edge, samples flags in the same settled window, and keeps its directed checks on those exact cycle offsets. A scoreboard samples on the falling edge and compares `dout` with the queued word only in cycles where a read is accepted at the next edge. It also compares `level` with a running count kept by the bench.

// File: rtl/bfifo_pkg.sv
package bfifo_pkg;
  // Width of an index into n entries, at least one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bfifo_mem.sv
module bfifo_mem #(
  parameter int WIDTH = 8,
  parameter int WORDS = 3,
  parameter int AW    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);
  logic [WIDTH-1:0] store [WORDS];

  // Write port; no reset, so the array can map onto block RAM
  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Registered read port, read-before-write on an address collision
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/bfifo_ctrl.sv
module bfifo_ctrl #(
  parameter int WORDS = 3,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic          has_data
);
  localparam int CW = $clog2(WORDS + 1);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);
  localparam logic [CW-1:0] FULLC = CW'(WORDS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign has_data = (cnt != '0);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push && cnt == FULLC) |-> pop);
  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    pop |-> has_data);
endmodule

// File: rtl/bfifo_level.sv
module bfifo_level #(
  parameter int DEPTH = 4,
  parameter int LW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_acc,
  input  logic          rd_acc,
  output logic [LW-1:0] level,
  output logic          writable
);
  localparam logic [LW-1:0] TOP = LW'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) level <= '0;
    else begin
      case ({wr_acc, rd_acc})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign writable = (level < TOP);

  // R4
  level_cap_chk: assert property (@(posedge clk) disable iff (rst)
    level <= TOP);
endmodule

// File: rtl/bfifo_out.sv
module bfifo_out #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  logic             we,
  output logic             writable,
  output logic [WIDTH-1:0] dout,
  input  logic             re,
  output logic             readable,
  output logic [LW-1:0]    level
);
  import bfifo_pkg::*;

  localparam int INNER = DEPTH - 1;
  localparam int AW    = idx_w(INNER);

  logic          wr_acc, rd_acc, mem_pop, mem_has, out_full, run_q;
  logic [AW-1:0] wp, rp;

  assign wr_acc   = we && writable;
  assign rd_acc   = re && out_full;
  assign mem_pop  = mem_has && (!out_full || re);
  assign readable = out_full;

  bfifo_ctrl #(.WORDS(INNER), .AW(AW)) u_ctrl (
    .clk(clk), .rst(rst), .push(wr_acc), .pop(mem_pop),
    .wr_ptr(wp), .rd_ptr(rp), .has_data(mem_has)
  );

  bfifo_mem #(.WIDTH(WIDTH), .WORDS(INNER), .AW(AW)) u_mem (
    .clk(clk), .rst(rst), .wr_en(wr_acc), .wr_addr(wp), .wr_data(din),
    .rd_en(mem_pop), .rd_addr(rp), .rd_data(dout)
  );

  bfifo_level #(.DEPTH(DEPTH), .LW(LW)) u_level (
    .clk(clk), .rst(rst), .wr_acc(wr_acc), .rd_acc(rd_acc),
    .level(level), .writable(writable)
  );

  // Output stage valid flag
  always_ff @(posedge clk) begin
    if (rst)          out_full <= 1'b0;
    else if (mem_pop) out_full <= 1'b1;
    else if (rd_acc)  out_full <= 1'b0;
  end

  // High once the previous cycle was out of reset
  always_ff @(posedge clk) begin
    run_q <= !rst;
  end

  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> level == LW'($past(level) + LW'($past(wr_acc)) - LW'($past(rd_acc))));
  // R3
  empty_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |-> !readable);
  // R3
  multi_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (level > LW'(1)) |-> readable);
  // R5
  rise_chk: assert property (@(posedge clk) disable iff (rst)
    (!readable && level == LW'(1)) |=> readable);
  // R8
  hold_dout_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !$past(re) && !$rose(readable)) |-> $stable(dout));
endmodule

// File: tb/bfifo_out_tb.sv
`timescale 1ns/1ps
module bfifo_out_tb;
  localparam int W = 8;
  localparam int DEPTH = 4;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst = 1'b1, we = 1'b0, re = 1'b0;
  logic [W-1:0] din = '0;
  logic writable, readable;
  logic [W-1:0] dout;
  logic [LW-1:0] level;

  int total = 0, bad = 0, lvl_m = 0;
  logic [W-1:0] sb_q [$];

  bfifo_out #(.WIDTH(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .din(din), .we(we), .writable(writable),
    .dout(dout), .re(re), .readable(readable), .level(level)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [W-1:0] d, input bit r);
    we = w; din = d; re = r;
    @(posedge clk); #1;
  endtask

  // Scoreboard monitor: models accepted writes and reads at the falling edge
  always @(negedge clk) begin
    if (rst) lvl_m = 0;
    else begin
      chk(int'(level) == lvl_m, "R2 level", int'(level), lvl_m);
      if (readable && re) begin
        if (sb_q.size() == 0) chk(1'b0, "R7 unexpected read", int'(dout), -1);
        else begin
          logic [W-1:0] e;
          e = sb_q.pop_front();
          chk(dout == e, "R7 order", int'(dout), int'(e));
        end
        lvl_m--;
      end
      if (writable && we) begin
        sb_q.push_back(din);
        lvl_m++;
      end
    end
  end

  initial begin
    #1000000;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int acc;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1
    chk(level == 0, "R1 level", int'(level), 0);
    chk(!readable, "R1 readable", int'(readable), 0);
    chk(writable, "R1 writable", int'(writable), 1);

    // R10: read on empty queue
    step(0, '0, 1);
    chk(level == 0, "R10 level", int'(level), 0);
    chk(!readable, "R10 readable", int'(readable), 0);

    // R5: two-cycle latency from empty
    step(1, 8'hA5, 0);
    chk(!readable, "R5 one cycle", int'(readable), 0);
    step(0, '0, 0);
    chk(readable, "R5 two cycles", int'(readable), 1);
    chk(dout == 8'hA5, "R5 data", int'(dout), 'hA5);

    // R8 / R6: hold without read
    repeat (3) step(0, '0, 0);
    chk(readable, "R6 unread stays", int'(readable), 1);
    chk(dout == 8'hA5, "R8 hold", int'(dout), 'hA5);
    // R6: read the single word
    step(0, '0, 1);
    chk(!readable, "R6 drop", int'(readable), 0);
    chk(level == 0, "R6 level", int'(level), 0);

    // R9 / R4: fill, then attempt one more
    acc = 0;
    for (int i = 0; i < DEPTH + 1; i++) begin
      if (writable) acc++;
      step(1, W'(8'h10 + i), 0);
    end
    chk(acc == DEPTH, "R9 accepted", acc, DEPTH);
    chk(!writable, "R4 writable low", int'(writable), 0);
    step(1, 8'hEE, 0);
    chk(level == DEPTH, "R4 level held", int'(level), DEPTH);

    // R7: drain back to back
    acc = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (readable) acc++;
      step(0, '0, 1);
    end
    chk(acc == DEPTH, "R7 continuous reads", acc, DEPTH);
    chk(!readable, "R3 empty after drain", int'(readable), 0);

    // R2 / R7: stream with simultaneous write and read
    for (int i = 0; i < 20; i++) step(1, W'(8'h40 + 3 * i), 1);
    repeat (DEPTH + 3) step(0, '0, 1);
    chk(sb_q.size() == 0, "R7 all delivered", sb_q.size(), 0);
    chk(level == 0, "R2 final level", int'(level), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule